// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a one-bit serial delay line. Its effective length is chosen while it runs, anywhere from 1 to 64 stages, by a six-bit weighted length word. A select line picks the serial input from one of two data inputs. With the output wired back into the second input, a stored pattern circulates indefinitely. The block drives both the delayed bit and its complement.

The shift timing comes from two slow control inputs, a shift clock and an active-high gate, which are sampled in the system clock domain. A rising shift-clock edge while the gate is low causes one shift. A falling gate edge while the shift clock is high also causes one shift, so the gate can act as an alternate falling-edge clock. The storage always shifts its full depth and the output is taken from a selectable tap, so changing the length never corrupts stored bits. An active-low master reset clears every stage at once and is released in step with the system clock.

Top module: `prog_shift_reg`

## Requirements
- R1: The length is the weighted sum of `len_ctrl_i` plus one. Bit k has weight 2^k, so 0 gives 1 stage and all ones gives 64 stages.
- R2: A bit shifted in appears on `q_o` after exactly N shifts, where N is the programmed length, and it is not visible after fewer shifts.
- R3: On each shift the stored input bit is `data_a_i` when `src_sel_i` is 0 and `data_b_i` when it is 1.
- R4: A rising edge on `shift_clk_i` while `shift_gate_i` is low causes exactly one shift, completed within 4 `clk` cycles.
- R5: While `shift_gate_i` is high, rising edges on `shift_clk_i` cause no shift and leave `q_o` unchanged.
- R6: A falling edge on `shift_gate_i` while `shift_clk_i` is high causes exactly one shift. Raising the gate, or lowering the shift clock, causes none.
- R7: `qn_o` is always the complement of `q_o`.
- R8: While `rst_n` is low, every stage is cleared without waiting for a clock edge, so `q_o` is 0 and `qn_o` is 1.
- R9: No shift takes place while reset is being released, even if `shift_clk_i` is high and the gate is low at that moment.
- R10: A change of `len_ctrl_i` between shifts moves the output to the new tap of the already stored data and loses no bits.
- R11: A rising shift-clock edge and a falling gate edge that arrive in the same cycle give one shift, not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| shift_clk_i | input | 1 | Shift clock; its rising edge shifts when the gate is low |
| shift_gate_i | input | 1 | Shift gate; high blocks shifting, and its falling edge shifts when the shift clock is high |
| src_sel_i | input | 1 | Serial source select: 0 = data A, 1 = data B |
| data_a_i | input | 1 | Serial data input A |
| data_b_i | input | 1 | Serial data input B (recirculation input) |
| len_ctrl_i | input | 6 | Weighted length word; length = value + 1 |
| q_o | output | 1 | Delayed serial output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
Two shift triggers can coincide: a rising shift-clock edge and a falling gate edge. The bench changes both inputs on the same clock, so both edges reach the synchroniser outputs together. It sets the length to two stages and shifts in a bit that differs from the newest stored bit. One shift shows the old bit on the output and a double shift would show the new one, so the output value tells the two cases apart. A bit-accurate reference of all 64 stages gives the expected output for every length, including mid-stream length changes and recirculation through input B.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_DEPTH_DEF = 64;
  localparam int unsigned PSR_SYNC_DEF  = 2;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_sel_e;
endpackage

// File: rtl/psr_reset_sync.sv
module psr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/psr_edge_strobe.sv
module psr_edge_strobe #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_clk_i,
  input  logic gate_i,
  output logic stb_o
);
  localparam int unsigned ARM_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] clk_sync_q, clk_sync_d;
  logic [SYNC_STAGES-1:0] gate_sync_q, gate_sync_d;
  logic                   clk_prev_q, gate_prev_q;
  logic [ARM_W-1:0]       arm_q, arm_d;
  logic                   clk_s, gate_s;
  logic                   clk_rise, gate_fall;

  // next-state
  always_comb begin
    clk_sync_d  = {clk_sync_q[SYNC_STAGES-2:0], shift_clk_i};
    gate_sync_d = {gate_sync_q[SYNC_STAGES-2:0], gate_i};
    arm_d       = {arm_q[ARM_W-2:0], 1'b1};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync_q  <= '0;
      gate_sync_q <= '0;
      clk_prev_q  <= 1'b0;
      gate_prev_q <= 1'b0;
      arm_q       <= '0;
    end else begin
      clk_sync_q  <= clk_sync_d;
      gate_sync_q <= gate_sync_d;
      clk_prev_q  <= clk_sync_q[SYNC_STAGES-1];
      gate_prev_q <= gate_sync_q[SYNC_STAGES-1];
      arm_q       <= arm_d;
    end
  end

  // strobe: rising shift clock with gate low, or falling gate with clock high
  always_comb begin
    clk_s     = clk_sync_q[SYNC_STAGES-1];
    gate_s    = gate_sync_q[SYNC_STAGES-1];
    clk_rise  = clk_s & ~clk_prev_q;
    gate_fall = ~gate_s & gate_prev_q;
    stb_o     = arm_q[ARM_W-1] & ~gate_s & (clk_rise | (gate_fall & clk_s));
  end
endmodule

// File: rtl/psr_tap_chain.sv
module psr_tap_chain #(
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [DEPTH-1:0] store_o
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb stage_d[g] = shift_i ? din_i : stage_q[g];
    end else begin : g_body
      always_comb stage_d[g] = shift_i ? stage_q[g-1] : stage_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign store_o = stage_q;
endmodule

// File: rtl/prog_shift_reg.sv
module prog_shift_reg
  import psr_pkg::*;
#(
  parameter int unsigned DEPTH       = PSR_DEPTH_DEF,
  parameter int unsigned SYNC_STAGES = PSR_SYNC_DEF,
  localparam int unsigned LEN_W      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk_i,
  input  logic             shift_gate_i,
  input  logic             src_sel_i,
  input  logic             data_a_i,
  input  logic             data_b_i,
  input  logic [LEN_W-1:0] len_ctrl_i,
  output logic             q_o,
  output logic             qn_o
);
  logic             rst_sync_n;
  logic             shift_stb;
  logic             din_sel;
  logic [DEPTH-1:0] store;

  psr_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psr_edge_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .shift_clk_i (shift_clk_i),
    .gate_i      (shift_gate_i),
    .stb_o       (shift_stb)
  );

  always_comb begin
    din_sel = (src_sel_e'(src_sel_i) == SRC_B) ? data_b_i : data_a_i;
  end

  psr_tap_chain #(.DEPTH(DEPTH)) u_chain (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .shift_i (shift_stb),
    .din_i   (din_sel),
    .store_o (store)
  );

  // length = len_ctrl_i + 1, so the tap index is len_ctrl_i itself
  always_comb begin
    q_o  = store[len_ctrl_i];
    qn_o = ~q_o;
  end
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int unsigned DEPTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             shift_stb,
  input logic             din,
  input logic [DEPTH-1:0] store,
  input logic             q_o,
  input logic             qn_o
);
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shift_stb |=> $stable(store));  // R5

  AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_stb |=> store[0] == $past(din));  // R3

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_stb |=> store[DEPTH-1:1] == $past(store[DEPTH-2:0]));  // R2

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (store == '0) && !q_o && qn_o);  // R8

  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> !shift_stb);  // R9

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    qn_o != q_o);  // R7
endmodule

bind prog_shift_reg psr_checker #(.DEPTH(DEPTH)) u_psr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .shift_stb  (shift_stb),
  .din        (din_sel),
  .store      (store),
  .q_o        (q_o),
  .qn_o       (qn_o)
);

// File: tb/test_prog_shift_reg.sv
module test_prog_shift_reg;
  localparam int DEPTH = 64;
  localparam int NVEC  = 20;
  // {len[5:0], sel, a, b}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b000000_0_1_0, 9'b000000_0_0_1, 9'b000001_1_0_1, 9'b000001_1_1_0,
    9'b000011_0_1_1, 9'b000011_1_1_0, 9'b000011_0_0_0, 9'b000010_1_0_1,
    9'b000010_0_1_0, 9'b000111_1_1_1, 9'b000111_0_0_1, 9'b000111_1_0_1,
    9'b000100_0_1_0, 9'b000100_1_1_0, 9'b000000_1_0_1, 9'b000000_0_0_0,
    9'b000101_1_1_0, 9'b000101_0_1_1, 9'b000110_1_0_0, 9'b000110_0_1_0
  };

  logic clk = 1'b0;
  logic rst_n, shift_clk, gate, sel, da, db;
  logic [5:0] len;
  logic q, qn;
  logic [DEPTH-1:0] mdl;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  prog_shift_reg i_prog_shift_reg (
    .clk(clk), .rst_n(rst_n), .shift_clk_i(shift_clk), .shift_gate_i(gate),
    .src_sel_i(sel), .data_a_i(da), .data_b_i(db), .len_ctrl_i(len),
    .q_o(q), .qn_o(qn)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check(req, q, mdl[len]);
    check("R7", qn, ~mdl[len]);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // rising shift clock with gate low; model shifts the selected bit
  task automatic pulse();
    logic b;
    b = sel ? db : da;
    @(negedge clk) shift_clk = 1'b1;
    wait_cyc(4);
    mdl = {mdl[DEPTH-2:0], b};
    shift_clk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    mdl = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    rst_n = 1'b0; shift_clk = 1'b0; gate = 1'b0; sel = 1'b0;
    da = 1'b0; db = 1'b0; len = '0; mdl = '0;
    wait_cyc(3);
    check("R8", q, 1'b0);
    check("R8", qn, 1'b1);
    rst_n = 1'b1;
    wait_cyc(6);

    // vector table: R3 source select, R1 tap per length
    foreach (VEC[i]) begin
      len = VEC[i][8:3]; sel = VEC[i][2]; da = VEC[i][1]; db = VEC[i][0];
      pulse();
      check_out("R3");
    end

    // R1/R2 length sweep over every length value
    for (int l = 0; l < DEPTH; l++) begin
      len = 6'(l); sel = 1'b0;
      for (int k = 0; k < l + 2; k++) begin
        da = ((k * 7 + l) % 3) == 0;
        pulse();
        check_out("R1");
      end
    end

    // R2: single one at full length is not visible early
    do_reset();
    len = 6'd63; sel = 1'b0; da = 1'b1;
    pulse();
    da = 1'b0;
    for (int k = 2; k <= 65; k++) begin
      pulse();
      check("R2", q, (k == 64));
    end

    // R10: change length between shifts without shifting
    for (int k = 0; k < 40; k++) begin da = (k % 5) < 2; pulse(); end
    for (int l = 0; l < DEPTH; l += 9) begin
      len = 6'(l);
      wait_cyc(2);
      check_out("R10");
    end
    len = 6'd5; da = 1'b1; pulse(); check_out("R10");

    // R3 recirculation: feed output back through B
    len = 6'd6; sel = 1'b1;
    for (int k = 0; k < 21; k++) begin
      db = q;
      pulse();
      check_out("R3");
    end
    sel = 1'b0;

    // R5: gate high blocks rising shift-clock edges
    len = 6'd0; da = ~mdl[0];
    gate = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) shift_clk = 1'b1; wait_cyc(4);
      shift_clk = 1'b0; wait_cyc(4);
      check_out("R5");
    end

    // R6: falling gate while shift clock high shifts once
    len = 6'd1; da = ~mdl[0];
    @(negedge clk) shift_clk = 1'b1; wait_cyc(5);
    check_out("R6");
    gate = 1'b0; wait_cyc(5);
    mdl = {mdl[DEPTH-2:0], da};
    check_out("R6");
    shift_clk = 1'b0; wait_cyc(5);
    gate = 1'b1; wait_cyc(5);
    check_out("R6");

    // R11: shift-clock rise and gate fall in the same cycle -> one shift
    len = 6'd1; da = ~mdl[0];
    @(negedge clk) begin shift_clk = 1'b1; gate = 1'b0; end
    wait_cyc(6);
    mdl = {mdl[DEPTH-2:0], da};
    check_out("R11");
    shift_clk = 1'b0; wait_cyc(5);
    check_out("R11");

    // R4: plain rising edge with gate low
    da = ~mdl[0];
    pulse();
    check_out("R4");

    // R8: asynchronous clear between clock edges
    len = 6'd0; da = 1'b1; pulse();
    check("R8", q, 1'b1);
    @(negedge clk) #1 rst_n = 1'b0;
    #0.5;
    check("R8", q, 1'b0);
    check("R8", qn, 1'b1);
    mdl = '0;
    // R9: release with shift clock high and gate low
    shift_clk = 1'b1; gate = 1'b0; da = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(10);
    check("R9", q, 1'b0);
    shift_clk = 1'b0; wait_cyc(5);
    check("R9", q, 1'b0);
    pulse();
    check_out("R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule